// File: doc/BRIEF.md
# Cascaded Half-Band Interpolator

This block raises the sample rate of a signed sample stream headed for a digital-to-analog converter by a factor of 1, 2, 4 or 8. Every doubling is done by one identical 2x stage. The stage puts a zero between each pair of input samples and then runs the result through a fixed 7-tap half-band low-pass filter. This removes the image that sits around the old sample rate. The stages are chained in series, and a small factor control decides how many of them take part. The stages that do not take part become plain wires.

The block runs on one clock at the output sample rate. Input arrives on a valid/ready stream. Each active stage accepts one sample for every two output slots it fills, so the input side is paced down to the output rate divided by the factor. The last stage is never stalled, and its result leaves through one output register as a valid-qualified sample on every clock. After each stage the result is rounded and then clipped back to the input width. A filter gain of two per stage makes up for the energy lost to zero insertion.

Top module: `hbi_interp`

## Requirements
- R1: A factor code k on `rate_sel` (0, 1, 2 or 3) selects the factor F = 2^k. Every accepted input sample produces exactly F output samples. While input is offered on every cycle, `out_valid` stays high on every cycle from the first output onward.
- R2: A 2x stage with inputs x[m] emits two samples per input, in order y[2m] then y[2m+1]. It behaves like zero insertion followed by the taps (-1, 0, 9, 16, 9, 0, -1)/16, so its DC gain is 2. This gives y[2m] = (-x[m] + 9x[m-1] + 9x[m-2] - x[m-3])/16 and y[2m+1] = x[m-1]. Samples before the first are zero, so a unit impulse of height A at factor 2 yields -A/16, 0, 9A/16, A, 9A/16, 0, -A/16, 0.
- R3: The division by 16 in each stage rounds half upward: result = floor((acc + 8) / 16).
- R4: Each stage clips its rounded result to the signed two's-complement range of the data width (-32768 to 32767 at 16 bits) before the next stage sees it.
- R5: Factor 4 is two 2x stages in series and factor 8 is three. Each stage takes the previous stage's clipped output as its input. The output for a single-sample impulse equals the cascade of the per-stage responses.
- R6: At factor 1, `in_ready` is high and each accepted sample appears unchanged on `out_data`, with `out_valid` high, one cycle after acceptance.
- R7: The first output sample appears k+1 cycles after the cycle in which the first input sample is accepted: one cycle per active stage plus one for the output register.
- R8: When k is at least 1, `in_ready` is low in the cycle that follows an accepted input, as long as the factor did not change.
- R9: If `rate_sel` differs from its value in the previous cycle, `in_ready` is low in that cycle and `out_valid` is low in the next one. All filter history is discarded, so the samples that follow are filtered from a zero history.
- R10: During and right after a synchronous reset `out_valid` is low, and once reset is released with a steady factor `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the output sample rate |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | SEL_W (2) | Factor code k, factor 2^k |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample taken at this edge when valid |
| in_data | input | DATA_W (16) | Signed input sample |
| out_valid | output | 1 | Output sample present this cycle |
| out_data | output | DATA_W (16) | Signed interpolated sample |

## Verification
The bench builds the block with its defaults: a 16-bit sample width and three stages. This makes every factor code reachable, including the full three-stage cascade, and it puts the true 16-bit rails within reach of patterns that overdrive the even-phase sum. Expected streams come from a direct zero-stuff-and-convolve model applied once per stage. The model is checked against impulses whose heights exercise the rounding half-step, against ramps and against pseudo-random runs. A mid-stream change of factor shows that history is dropped, and the pacing of `in_ready`, the latency per factor and gap-free output are all measured.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    // Non-zero half-band taps; the centre tap equals 1 << HB_SHIFT.
    localparam int HB_OUTER = -1;
    localparam int HB_INNER = 9;
    localparam int HB_SHIFT = 4;
    // Headroom bits above the sample width for the even-phase sum.
    localparam int HB_GUARD = 6;

    // What a stage's output register currently holds.
    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_EVEN_OUT = 2'd1,
        ST_ODD_OUT  = 2'd2
    } stage_state_e;

    // Number of stages engaged for a factor code, clamped to the chain length.
    function automatic int active_count(input int code, input int n_stages);
        return (code > n_stages) ? n_stages : code;
    endfunction

    // The engaged stages are the last ones in the chain, nearest the output.
    function automatic logic stage_enabled(input int idx, input int n_stages, input int code);
        return logic'(idx >= (n_stages - active_count(code, n_stages)));
    endfunction

endpackage

// File: rtl/hbi_hb_even.sv
module hbi_hb_even
    import hbi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] x_new,
    input  logic signed [DATA_W-1:0] x_d1,
    input  logic signed [DATA_W-1:0] x_d2,
    input  logic signed [DATA_W-1:0] x_d3,
    output logic signed [DATA_W-1:0] y
);
    localparam int ACC_W = DATA_W + HB_GUARD;
    localparam logic signed [ACC_W-1:0] INNER_K = ACC_W'(HB_INNER);
    localparam logic signed [ACC_W-1:0] OUTER_K = ACC_W'(HB_OUTER);
    localparam logic signed [ACC_W-1:0] RND     = ACC_W'(1 << (HB_SHIFT - 1));
    localparam logic signed [ACC_W-1:0] MAX_V   =
        {{(ACC_W - DATA_W + 1){1'b0}}, {(DATA_W - 1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_V   =
        {{(ACC_W - DATA_W + 1){1'b1}}, {(DATA_W - 1){1'b0}}};

    logic signed [ACC_W-1:0] inner_sum;
    logic signed [ACC_W-1:0] outer_sum;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        // Symmetric taps: add the pairs first, then one product per pair.
        inner_sum = ACC_W'(x_d1) + ACC_W'(x_d2);
        outer_sum = ACC_W'(x_new) + ACC_W'(x_d3);
        acc       = (inner_sum * INNER_K) + (outer_sum * OUTER_K);
        scaled    = (acc + RND) >>> HB_SHIFT;
        if (scaled > MAX_V) begin
            y = MAX_V[DATA_W-1:0];
        end else if (scaled < MIN_V) begin
            y = MIN_V[DATA_W-1:0];
        end else begin
            y = scaled[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/hbi_stage.sv
module hbi_stage
    import hbi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     active,
    input  logic                     s_valid,
    output logic                     s_ready,
    input  logic signed [DATA_W-1:0] s_data,
    output logic                     m_valid,
    input  logic                     m_ready,
    output logic signed [DATA_W-1:0] m_data
);
    localparam int HIST = 3;

    stage_state_e             st_q;
    logic signed [DATA_W-1:0] hist_q [HIST];
    logic signed [DATA_W-1:0] hold_q;
    logic signed [DATA_W-1:0] even_val;
    logic                     can_take;
    logic                     take_in;

    hbi_hb_even #(.DATA_W(DATA_W)) u_even (
        .x_new (s_data),
        .x_d1  (hist_q[0]),
        .x_d2  (hist_q[1]),
        .x_d3  (hist_q[2]),
        .y     (even_val)
    );

    // A new sample is taken when nothing is held, or when the odd phase leaves now.
    assign can_take = (st_q == ST_EMPTY) || ((st_q == ST_ODD_OUT) && m_ready);
    assign take_in  = active && s_valid && can_take;

    always_comb begin
        if (active) begin
            s_ready = can_take;
            m_valid = (st_q != ST_EMPTY);
            m_data  = hold_q;
        end else begin
            s_ready = m_ready;
            m_valid = s_valid;
            m_data  = s_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !active) begin
            st_q   <= ST_EMPTY;
            hold_q <= '0;
            for (int i = 0; i < HIST; i++) begin
                hist_q[i] <= '0;
            end
        end else if (take_in) begin
            hist_q[0] <= s_data;
            for (int i = 1; i < HIST; i++) begin
                hist_q[i] <= hist_q[i-1];
            end
            hold_q <= even_val;
            st_q   <= ST_EVEN_OUT;
        end else begin
            unique case (st_q)
                ST_EVEN_OUT: begin
                    if (m_ready) begin
                        // Odd phase: centre tap alone, i.e. the previous input.
                        hold_q <= hist_q[1];
                        st_q   <= ST_ODD_OUT;
                    end
                end
                ST_ODD_OUT: begin
                    if (m_ready) begin
                        st_q <= ST_EMPTY;
                    end
                end
                default: begin
                    st_q <= ST_EMPTY;
                end
            endcase
        end
    end

endmodule

// File: rtl/hbi_out_reg.sv
module hbi_out_reg #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     d_valid,
    input  logic signed [DATA_W-1:0] d_data,
    output logic                     q_valid,
    output logic signed [DATA_W-1:0] q_data
);
    typedef struct packed {
        logic                     valid;
        logic signed [DATA_W-1:0] data;
    } beat_t;

    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            beat_q <= '0;
        end else begin
            beat_q.valid <= d_valid;
            beat_q.data  <= d_data;
        end
    end

    assign q_valid = beat_q.valid;
    assign q_data  = beat_q.data;

endmodule

// File: rtl/hbi_interp.sv
module hbi_interp
    import hbi_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_STAGES = 3,
    parameter int SEL_W      = $clog2(NUM_STAGES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SEL_W-1:0]         rate_sel,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);
    localparam int LINKS = NUM_STAGES + 1;

    logic [SEL_W-1:0]         rate_q;
    logic                     flush;
    logic [LINKS-1:0]         lnk_valid;
    logic [LINKS-1:0]         lnk_ready;
    logic signed [DATA_W-1:0] lnk_data [LINKS];
    logic [NUM_STAGES-1:0]    stage_on;

    always_ff @(posedge clk) begin
        rate_q <= rate_sel;
    end

    // A factor change drops everything in flight and blocks input for one cycle.
    assign flush        = (rate_sel != rate_q);
    assign lnk_valid[0] = in_valid && !flush;
    assign lnk_data[0]  = in_data;
    assign in_ready     = lnk_ready[0] && !flush;
    // The output register never stalls the last stage.
    assign lnk_ready[NUM_STAGES] = 1'b1;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        assign stage_on[g] = stage_enabled(g, NUM_STAGES, int'(rate_q));

        hbi_stage #(.DATA_W(DATA_W)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .clear   (flush),
            .active  (stage_on[g]),
            .s_valid (lnk_valid[g]),
            .s_ready (lnk_ready[g]),
            .s_data  (lnk_data[g]),
            .m_valid (lnk_valid[g+1]),
            .m_ready (lnk_ready[g+1]),
            .m_data  (lnk_data[g+1])
        );
    end

    hbi_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .clear   (flush),
        .d_valid (lnk_valid[NUM_STAGES]),
        .d_data  (lnk_data[NUM_STAGES]),
        .q_valid (out_valid),
        .q_data  (out_data)
    );

endmodule

// File: rtl/hbi_interp_chk.sv
module hbi_interp_chk #(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic [SEL_W-1:0]         rate_sel,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic signed [DATA_W-1:0] in_data,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_data
);

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == '0 && $past(rate_sel) == '0 && $past(in_valid && in_ready) && !$past(rst))
        |-> (out_valid && out_data == $past(in_data))); // R6

    AST_BYPASS_READY: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == '0 && $past(rate_sel) == '0 && !$past(rst)) |-> in_ready); // R6

    AST_PACED_READY: assert property (@(posedge clk) disable iff (rst)
        (rate_sel != '0 && rate_sel == $past(rate_sel) && $past(in_valid && in_ready) && !$past(rst))
        |-> !in_ready); // R8

    AST_CHANGE_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (rate_sel != $past(rate_sel)) |-> !in_ready); // R9

    AST_CHANGE_DROPS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (rate_sel != $past(rate_sel)) |=> !out_valid); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> !out_valid); // R10

endmodule

bind hbi_interp hbi_interp_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rate_sel  (rate_sel),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/hbi_interp_tb.sv
`timescale 1ns/1ps
module hbi_interp_tb;
    localparam int DATA_W = 16;
    localparam int MAXV   = 32767;
    localparam int MINV   = -32768;
    localparam int BUF    = 256;
    localparam int NCASE  = 9;
    localparam int TAP [7] = '{-1, 0, 9, 16, 9, 0, -1};

    // {factor code[28:27], pattern[26:24], amplitude[23:8], input count[7:0]}
    // patterns: 0 impulse, 1 ramp, 2 overdrive high, 3 overdrive low, 4 pseudo-random
    localparam logic [28:0] CASES [NCASE] = '{
        {2'd0, 3'd1, 16'd100,   8'd12},
        {2'd1, 3'd0, 16'd1600,  8'd8},
        {2'd1, 3'd0, 16'd8,     8'd6},
        {2'd2, 3'd0, 16'd1024,  8'd8},
        {2'd3, 3'd0, 16'd2048,  8'd8},
        {2'd1, 3'd2, 16'd0,     8'd8},
        {2'd2, 3'd3, 16'd0,     8'd8},
        {2'd3, 3'd4, 16'd30000, 8'd20},
        {2'd1, 3'd4, 16'd20000, 8'd16}
    };

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [1:0]               rate_sel = 2'd0;
    logic                     in_valid = 1'b0;
    logic                     in_ready;
    logic signed [DATA_W-1:0] in_data = '0;
    logic                     out_valid;
    logic signed [DATA_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int stim_arr [BUF];
    int exp_arr  [BUF];
    int got_arr  [BUF];
    int n_exp;
    int first_acc;
    int first_out;
    int gaps;
    int pace_bad;
    int n_got;

    hbi_interp u_dut (
        .clk       (clk),
        .rst       (rst),
        .rate_sel  (rate_sel),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int pat, input int code);
        if (code == 0) return "R6";
        case (pat)
            0: return (code == 1) ? "R2" : "R5";
            2, 3: return "R4";
            default: return "R1";
        endcase
    endfunction

    function automatic int stim_val(input int pat, input int amp, input int k);
        case (pat)
            0: return (k == 0) ? amp : 0;
            1: return amp * (k - 5);
            2: case (k)
                   0: return MINV; 1: return MAXV; 2: return MAXV; 3: return MINV;
                   default: return 0;
               endcase
            3: case (k)
                   0: return MAXV; 1: return MINV; 2: return MINV; 3: return MAXV;
                   default: return 0;
               endcase
            default: return (((k * 4871 + 1237) % 2001) - 1000) * amp / 1000;
        endcase
    endfunction

    // Zero-stuff then convolve with the full tap list, round half up, clip.
    task automatic model(input int nin, input int nst);
        int cur [BUF];
        int nxt [BUF];
        int n;
        n = nin;
        for (int i = 0; i < BUF; i++) cur[i] = (i < nin) ? stim_arr[i] : 0;
        for (int s = 0; s < nst; s++) begin
            for (int o = 0; o < 2 * n; o++) begin
                int acc;
                int r;
                acc = 0;
                for (int k = 0; k < 7; k++) begin
                    int j;
                    j = o - k;
                    if (j >= 0 && (j % 2) == 0) acc += TAP[k] * cur[j / 2];
                end
                r = (acc + 8) >>> 4;
                if (r > MAXV) r = MAXV;
                if (r < MINV) r = MINV;
                nxt[o] = r;
            end
            n = 2 * n;
            for (int i = 0; i < n; i++) cur[i] = nxt[i];
        end
        for (int i = 0; i < n; i++) exp_arr[i] = cur[i];
        n_exp = n;
    endtask

    task automatic do_reset(input logic [1:0] code);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        rate_sel = code;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Offer nin samples as fast as accepted (then zeros) and collect nin*F outputs.
    task automatic run_stream(input int nin, input int code);
        int idx;
        int guard;
        bit prev_acc;
        idx = 0;
        n_got = 0;
        first_acc = -1;
        first_out = -1;
        gaps = 0;
        pace_bad = 0;
        prev_acc = 1'b0;
        guard = 0;
        while (n_got < (nin << code) && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (out_valid) begin
                got_arr[n_got] = int'(out_data);
                n_got++;
                if (first_out < 0) first_out = cyc;
            end else if (first_out >= 0) begin
                gaps++;
            end
            in_valid = 1'b1;
            in_data  = DATA_W'((idx < nin) ? stim_arr[idx] : 0);
            #1;
            if (code != 0 && prev_acc && in_ready) pace_bad++;
            prev_acc = in_ready;
            if (in_ready) begin
                if (idx == 0) first_acc = cyc;
                idx++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(n_got == (nin << code), "R1", n_got, nin << code, "output sample count");
    endtask

    task automatic compare(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < n_exp; i++) begin
            if (got_arr[i] != exp_arr[i]) begin
                bad++;
                chk(1'b0, req, got_arr[i], exp_arr[i], $sformatf("sample %0d", i));
            end
        end
        chk(bad == 0, req, bad, 0, "mismatching samples in stream");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state
        do_reset(2'd1);
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R10", int'(out_valid), 0, "out_valid after reset");
        chk(in_ready == 1'b1, "R10", int'(in_ready), 1, "in_ready after reset");

        // Vector table walk
        for (int c = 0; c < NCASE; c++) begin
            int code;
            int pat;
            int amp;
            int nin;
            string req;
            code = int'(CASES[c][28:27]);
            pat  = int'(CASES[c][26:24]);
            amp  = int'(CASES[c][23:8]);
            nin  = int'(CASES[c][7:0]);
            req  = tag_of(pat, code);
            for (int k = 0; k < BUF; k++) stim_arr[k] = (k < nin) ? stim_val(pat, amp, k) : 0;
            if (c == 2) req = "R3";
            model(nin, code);
            do_reset(2'(code));
            run_stream(nin, code);
            compare(req);
            chk(first_out - first_acc == code + 1, "R7", first_out - first_acc, code + 1, "first-output latency");
            chk(gaps == 0, "R1", gaps, 0, "idle output cycles inside stream");
            chk(pace_bad == 0, "R8", pace_bad, 0, "ready right after an accept");
            if (c == 1) begin
                // Hand-written impulse response of one stage, height 1600 (R2)
                int ref_imp [8];
                ref_imp = '{-100, 0, 900, 1600, 900, 0, -100, 0};
                for (int i = 0; i < 8; i++)
                    chk(got_arr[i] == ref_imp[i], "R2", got_arr[i], ref_imp[i], $sformatf("impulse tap %0d", i));
            end
            if (c == 2) begin
                // Height 8: -0.5 rounds to 0, 4.5 rounds to 5 (R3)
                chk(got_arr[0] == 0, "R3", got_arr[0], 0, "half-step negative rounding");
                chk(got_arr[2] == 5, "R3", got_arr[2], 5, "half-step positive rounding");
            end
            if (c == 5) chk(got_arr[6] == MAXV, "R4", got_arr[6], MAXV, "upper clip");
        end

        // Factor change mid-stream drops history (R9)
        do_reset(2'd3);
        @(negedge clk);
        in_valid = 1'b1;
        for (int k = 0; k < 12; k++) begin
            in_data = DATA_W'(stim_val(4, 25000, k));
            @(negedge clk);
        end
        rate_sel = 2'd2;
        in_data  = DATA_W'(12345);
        #1;
        chk(in_ready == 1'b0, "R9", int'(in_ready), 0, "in_ready on factor change");
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R9", int'(out_valid), 0, "out_valid after factor change");
        for (int k = 0; k < BUF; k++) stim_arr[k] = (k == 0) ? 3000 : 0;
        model(8, 2);
        run_stream(8, 2);
        compare("R9");
        chk(first_out - first_acc == 3, "R7", first_out - first_acc, 3, "latency after factor change");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule